// File: doc/BRIEF.md
# Access Violation Capture Unit

This unit sits beside a bus access-permission checker and keeps a record of the accesses that the checker refuses. Each refused access arrives as a one-cycle event. The event carries the violating master, its domain, the read and write flags, and the full address. It also names the slave port it hit and the slave group that the port belongs to. Every slave port has its own status bit, and each bit can be masked from the interrupt. The interrupt is raised while any unmasked status bit is set.

The details of a violation are not kept in readable registers. Each group stores its first unread violation internally and raises a pending bit in a shift-status register. To fetch the details, software does the following steps in order:

1. It takes the lowest pending group.
2. It writes that group's one-hot code to a select register.
3. It writes 1 to a shift-control register.
4. It polls until the register reads 3. By then the unit has shifted the 64 stored bits one per clock into two shared debug words.
5. It reads the debug words.
6. It writes 0 to shift control to end the transfer.
7. It writes the group's bit back to shift status to clear that group.

A global control register turns violation capture on and off.

Top module: `avcu_top`

Register map (byte offsets): mask words at 0x000 + 4·k, status words at 0x100 + 4·k, debug word 0 at 0x200, debug word 1 at 0x204, global control at 0x300, shift status at 0x310, shift select at 0x314, shift control at 0x320.

## Requirements
- R1: After reset the following registers read 0: global control, shift status, shift select, shift control, every status word, and both debug words. Every implemented mask bit reads 1, and irq is 0.
- R2: A write to global control with bit 31 set enables capture. A write with bit 31 clear and bit 2 set disables it. Bit 31 reads back the enable state. While capture is disabled, violation events change no status or pending bit.
- R3: An enabled violation for group g, when g has nothing pending, stores its details and sets bit g of shift status.
- R4: An enabled violation for a group that already has a pending violation is dropped. The stored details are kept, and a sticky overflow flag for that group is set. The flag appears as bit 28 of debug word 0 when that group is transferred.
- R5: Writing 1 to shift control while shift select holds exactly one set bit starts a transfer. Shift control reads 0x1 for 63 cycles after the write edge, and reads 0x3 from the 64th cycle on.
- R6: Writing 0 to shift control clears both the start bit and the done bit, so the register reads 0.
- R7: Writing a value to shift status clears exactly the pending bits set in that value, together with their overflow flags. All other pending bits are unchanged.
- R8: Writing 1 to shift control while shift select is zero or has more than one set bit has no effect. Shift control stays 0 and never reports done.
- R9: A violation on slave index s sets bit s mod 32 of status word s/32. Slave indices at or above the slave count are ignored. Writing ones to a status word clears just those bits. Bits beyond the slave count read 0 in both the status array and the mask array.
- R10: irq is high exactly while some status bit is set and its mask bit is 0. It stays high until software clears or masks every such bit.
- R11: After a completed transfer, debug word 0 holds the group's stored details as follows: master ID in [15:0], domain in [21:16], write flag in bit 22, read flag in bit 23, upper address bits in [27:24], overflow in bit 28, and zero in [31:29]. Debug word 1 holds the 32-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the unit |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| vio_valid | input | 1 | One-cycle violation event |
| vio_group | input | GRP_W | Group of the violated slave |
| vio_slave | input | SLV_W | Index of the violated slave |
| vio_master | input | 16 | Violating master ID |
| vio_domain | input | 6 | Violating domain ID |
| vio_is_write | input | 1 | The access was a write |
| vio_is_read | input | 1 | The access was a read |
| vio_addr_hi | input | 4 | Upper address bits above bit 31 |
| vio_addr | input | 32 | Low 32 address bits |
| irq | output | 1 | Violation interrupt |

## Verification
The assertions assume the following about the bus: each write lasts a single cycle; software changes shift select only while no transfer is running; and violation events never fall in the same cycle as a shift-status write. The assertion on shift-status clearing is guarded against that overlap rather than relying on it. The stimulus drives every write and event from its own task, one at a time. It polls and reads only in cycles with no write. It always ends a transfer before it loads a new select value, so the stimulus stays inside these assumptions.

// File: rtl/avcu_pkg.sv
package avcu_pkg;

  localparam int DETAIL_BITS = 64;

  localparam logic [11:0] ADR_MASK_BASE = 12'h000;
  localparam logic [11:0] ADR_STAT_BASE = 12'h100;
  localparam logic [11:0] ADR_DBG_LO    = 12'h200;
  localparam logic [11:0] ADR_DBG_HI    = 12'h204;
  localparam logic [11:0] ADR_GCTRL     = 12'h300;
  localparam logic [11:0] ADR_SH_STAT   = 12'h310;
  localparam logic [11:0] ADR_SH_SEL    = 12'h314;
  localparam logic [11:0] ADR_SH_CTRL   = 12'h320;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  addr_hi;
    logic        is_read;
    logic        is_write;
    logic [5:0]  domain;
    logic [15:0] master;
  } vio_info_t;

  // Shifted image: low word is debug word 0, high word is debug word 1.
  function automatic logic [DETAIL_BITS-1:0] pack_detail(vio_info_t info, logic ovf);
    return {info.addr, 3'b000, ovf, info.addr_hi, info.is_read,
            info.is_write, info.domain, info.master};
  endfunction

endpackage

// File: rtl/avcu_slave_status.sv
module avcu_slave_status #(
  parameter int SLAVES = 40,
  parameter int SLV_W  = 6,
  parameter int WIDX_W = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [SLV_W-1:0]     set_idx,
  input  logic                 wr_stat,
  input  logic                 wr_mask,
  input  logic [WIDX_W-1:0]    wr_word,
  input  logic [31:0]          wdata,
  output logic [((SLAVES+31)/32)*32-1:0] stat_flat,
  output logic [((SLAVES+31)/32)*32-1:0] mask_flat,
  output logic                 irq
);
  localparam int WORDS = (SLAVES + 31) / 32;
  localparam int NBITS = WORDS * 32;

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    localparam int WRD = b / 32;
    localparam int POS = b % 32;
    if (b < SLAVES) begin : g_live
      logic stat_q, stat_d, mask_q, mask_d;
      logic word_hit;

      assign word_hit = (wr_word == WIDX_W'(WRD));

      always_comb begin
        stat_d = stat_q;
        if (wr_stat && word_hit && wdata[POS]) stat_d = 1'b0;
        if (set_en && (set_idx == SLV_W'(b)))  stat_d = 1'b1;
        mask_d = mask_q;
        if (wr_mask && word_hit) mask_d = wdata[POS];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stat_q <= 1'b0;
          mask_q <= 1'b1;
        end else begin
          stat_q <= stat_d;
          mask_q <= mask_d;
        end
      end

      assign stat_flat[b] = stat_q;
      assign mask_flat[b] = mask_q;
    end else begin : g_pad
      assign stat_flat[b] = 1'b0;
      assign mask_flat[b] = 1'b0;
    end
  end

  assign irq = |(stat_flat & ~mask_flat);

endmodule

// File: rtl/avcu_group_store.sv
module avcu_group_store
  import avcu_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int GRP_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  evt_en,
  input  logic [GRP_W-1:0]      evt_grp,
  input  vio_info_t             evt_info,
  input  logic                  clr_en,
  input  logic [GROUPS-1:0]     clr_bits,
  output logic [GROUPS-1:0]     pending,
  output logic [GROUPS-1:0][DETAIL_BITS-1:0] detail
);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic      pend_q, pend_d, ovf_q, ovf_d;
    vio_info_t info_q;
    logic      hit, clr_this, still_pend, cap_en;

    assign hit        = evt_en && (evt_grp == GRP_W'(g));
    assign clr_this   = clr_en && clr_bits[g];
    assign still_pend = pend_q && !clr_this;
    assign cap_en     = hit && !still_pend;

    always_comb begin
      pend_d = still_pend;
      ovf_d  = ovf_q && !clr_this;
      if (hit) begin
        if (still_pend) ovf_d  = 1'b1;
        else            pend_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        ovf_q  <= 1'b0;
      end else begin
        pend_q <= pend_d;
        ovf_q  <= ovf_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      info_q <= '0;
      else if (cap_en) info_q <= evt_info;
    end

    assign pending[g] = pend_q;
    assign detail[g]  = pack_detail(info_q, ovf_q);
  end

endmodule

// File: rtl/avcu_shift_engine.sv
module avcu_shift_engine
  import avcu_pkg::*;
#(
  parameter int SHIFT_LEN = DETAIL_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_req,
  input  logic                   stop_req,
  input  logic [SHIFT_LEN-1:0]   src_in,
  output logic                   start_q,
  output logic                   done_q,
  output logic [SHIFT_LEN-1:0]   dbg_word
);
  localparam int CW = $clog2(SHIFT_LEN);
  localparam logic [CW-1:0] LAST = CW'(SHIFT_LEN - 1);

  logic                 start_d, done_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [SHIFT_LEN-1:0] src_q, src_d, dbg_q, dbg_d;
  logic                 busy;

  assign busy = start_q && !done_q;

  always_comb begin
    start_d = start_q;
    done_d  = done_q;
    cnt_d   = cnt_q;
    src_d   = src_q;
    dbg_d   = dbg_q;
    if (stop_req) begin
      start_d = 1'b0;
      done_d  = 1'b0;
    end else if (start_req && !start_q) begin
      start_d = 1'b1;
      done_d  = 1'b0;
      cnt_d   = '0;
      src_d   = src_in;
    end else if (busy) begin
      src_d = src_q >> 1;
      dbg_d = {src_q[0], dbg_q[SHIFT_LEN-1:1]};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      src_q   <= '0;
      dbg_q   <= '0;
    end else begin
      start_q <= start_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
      src_q   <= src_d;
      dbg_q   <= dbg_d;
    end
  end

  assign dbg_word = dbg_q;

endmodule

// File: rtl/avcu_top.sv
module avcu_top
  import avcu_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int SLAVES = 40,
  parameter int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  parameter int SLV_W  = (SLAVES > 1) ? $clog2(SLAVES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              vio_valid,
  input  logic [GRP_W-1:0]  vio_group,
  input  logic [SLV_W-1:0]  vio_slave,
  input  logic [15:0]       vio_master,
  input  logic [5:0]        vio_domain,
  input  logic              vio_is_write,
  input  logic              vio_is_read,
  input  logic [3:0]        vio_addr_hi,
  input  logic [31:0]       vio_addr,
  output logic              irq
);
  localparam int WORDS  = (SLAVES + 31) / 32;
  localparam int NBITS  = WORDS * 32;
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  // address decode
  logic [5:0] word_idx;
  logic       in_mask, in_stat;
  assign word_idx = bus_addr[7:2];
  assign in_mask  = (bus_addr[11:8] == ADR_MASK_BASE[11:8]) && (int'(word_idx) < WORDS)
                    && (bus_addr[1:0] == 2'b00);
  assign in_stat  = (bus_addr[11:8] == ADR_STAT_BASE[11:8]) && (int'(word_idx) < WORDS)
                    && (bus_addr[1:0] == 2'b00);

  logic wr_gctrl, wr_sel, wr_shctl, wr_shstat;
  assign wr_gctrl  = bus_we && (bus_addr == ADR_GCTRL);
  assign wr_sel    = bus_we && (bus_addr == ADR_SH_SEL);
  assign wr_shctl  = bus_we && (bus_addr == ADR_SH_CTRL);
  assign wr_shstat = bus_we && (bus_addr == ADR_SH_STAT);

  // global enable and select
  logic              en_q, en_d;
  logic [GROUPS-1:0] sel_q, sel_d;

  always_comb begin
    en_d = en_q;
    if (wr_gctrl) begin
      if (bus_wdata[31])     en_d = 1'b1;
      else if (bus_wdata[2]) en_d = 1'b0;
    end
    sel_d = wr_sel ? bus_wdata[GROUPS-1:0] : sel_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end

  logic evt_en;
  assign evt_en = vio_valid && en_q;

  vio_info_t evt_info;
  assign evt_info = '{addr: vio_addr, addr_hi: vio_addr_hi, is_read: vio_is_read,
                      is_write: vio_is_write, domain: vio_domain, master: vio_master};

  // per-slave status and mask
  logic [NBITS-1:0] stat_flat, mask_flat;

  avcu_slave_status #(.SLAVES(SLAVES), .SLV_W(SLV_W), .WIDX_W(WIDX_W)) u_slv (
    .clk      (clk),
    .rst_n    (srst_n),
    .set_en   (evt_en),
    .set_idx  (vio_slave),
    .wr_stat  (bus_we && in_stat),
    .wr_mask  (bus_we && in_mask),
    .wr_word  (word_idx[WIDX_W-1:0]),
    .wdata    (bus_wdata),
    .stat_flat(stat_flat),
    .mask_flat(mask_flat),
    .irq      (irq)
  );

  // per-group stores
  logic [GROUPS-1:0]                  grp_pending;
  logic [GROUPS-1:0][DETAIL_BITS-1:0] grp_detail;

  avcu_group_store #(.GROUPS(GROUPS), .GRP_W(GRP_W)) u_grp (
    .clk     (clk),
    .rst_n   (srst_n),
    .evt_en  (evt_en),
    .evt_grp (vio_group),
    .evt_info(evt_info),
    .clr_en  (wr_shstat),
    .clr_bits(bus_wdata[GROUPS-1:0]),
    .pending (grp_pending),
    .detail  (grp_detail)
  );

  // selected source for the shift
  logic [DETAIL_BITS-1:0] sel_src;
  always_comb begin
    sel_src = '0;
    for (int g = 0; g < GROUPS; g++)
      if (sel_q[g]) sel_src = sel_src | grp_detail[g];
  end

  logic sel_onehot, start_req, stop_req;
  assign sel_onehot = (sel_q != '0) && ((sel_q & (sel_q - 1'b1)) == '0);
  assign start_req  = wr_shctl && bus_wdata[0] && sel_onehot;
  assign stop_req   = wr_shctl && !bus_wdata[0];

  logic                   sh_start, sh_done;
  logic [DETAIL_BITS-1:0] dbg_word;

  avcu_shift_engine #(.SHIFT_LEN(DETAIL_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (srst_n),
    .start_req(start_req),
    .stop_req (stop_req),
    .src_in   (sel_src),
    .start_q  (sh_start),
    .done_q   (sh_done),
    .dbg_word (dbg_word)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (in_mask)      bus_rdata = mask_flat[word_idx[WIDX_W-1:0]*32 +: 32];
    else if (in_stat) bus_rdata = stat_flat[word_idx[WIDX_W-1:0]*32 +: 32];
    else begin
      case (bus_addr)
        ADR_DBG_LO:  bus_rdata = dbg_word[31:0];
        ADR_DBG_HI:  bus_rdata = dbg_word[63:32];
        ADR_GCTRL:   bus_rdata = {en_q, 31'd0};
        ADR_SH_STAT: bus_rdata = 32'(grp_pending);
        ADR_SH_SEL:  bus_rdata = 32'(sel_q);
        ADR_SH_CTRL: bus_rdata = {30'd0, sh_done, sh_start};
        default:     bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/avcu_checker.sv
module avcu_checker #(
  parameter int GROUPS = 4
) (
  input logic              clk,
  input logic              srst_n,
  input logic              bus_we,
  input logic [11:0]       bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              vio_valid,
  input logic              irq,
  input logic              en_q,
  input logic [GROUPS-1:0] grp_pending,
  input logic              sh_start,
  input logic              sh_done
);
  localparam logic [11:0] SH_STAT = 12'h310;
  localparam logic [11:0] SH_CTRL = 12'h320;

  a_r2_no_capture_when_off: assert property (@(posedge clk) disable iff (!srst_n)
    !en_q |=> ((grp_pending & ~$past(grp_pending)) == '0));

  a_r7_clear_only_written: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_we && bus_addr == SH_STAT && !vio_valid)
      |=> (grp_pending == ($past(grp_pending) & ~$past(bus_wdata[GROUPS-1:0]))));

  a_r6_stop_clears: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_we && bus_addr == SH_CTRL && !bus_wdata[0]) |=> (!sh_start && !sh_done));

  a_r5_done_follows_start: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(sh_done) |-> $past(sh_start));

  a_r5_done_with_start: assert property (@(posedge clk) disable iff (!srst_n)
    sh_done |-> sh_start);

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    (irq && !bus_we) |=> irq);

endmodule

bind avcu_top avcu_checker #(.GROUPS(GROUPS)) u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .vio_valid  (vio_valid),
  .irq        (irq),
  .en_q       (en_q),
  .grp_pending(grp_pending),
  .sh_start   (sh_start),
  .sh_done    (sh_done)
);

// File: tb/sim_avcu_top.sv
module sim_avcu_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        vio_valid;
  logic [1:0]  vio_group;
  logic [5:0]  vio_slave;
  logic [15:0] vio_master;
  logic [5:0]  vio_domain;
  logic        vio_is_write, vio_is_read;
  logic [3:0]  vio_addr_hi;
  logic [31:0] vio_addr;
  logic        irq;

  avcu_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vio_valid(vio_valid),
    .vio_group(vio_group), .vio_slave(vio_slave), .vio_master(vio_master),
    .vio_domain(vio_domain), .vio_is_write(vio_is_write), .vio_is_read(vio_is_read),
    .vio_addr_hi(vio_addr_hi), .vio_addr(vio_addr), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          is_irq;
    logic [11:0] addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    bad   = 0;
  bit    probe = 1'b0;
  bit    finished = 1'b0;

  // monitor: compare mid-cycle
  always @(negedge clk) begin
    if (probe && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {31'd0, irq} : bus_rdata;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it = '{is_irq: 1'b0, addr: a, exp: e, tag: tag};
    q.push_back(it);
    bus_addr = a;
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    it = '{is_irq: 1'b1, addr: 12'h0, exp: {31'd0, e}, tag: tag};
    q.push_back(it);
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic event_in(input logic [1:0] g, input logic [5:0] s, input logic [15:0] m,
                          input logic [5:0] dm, input logic w, input logic r,
                          input logic [3:0] hi, input logic [31:0] a);
    vio_valid = 1'b1; vio_group = g; vio_slave = s; vio_master = m; vio_domain = dm;
    vio_is_write = w; vio_is_read = r; vio_addr_hi = hi; vio_addr = a;
    @(posedge clk); #1;
    vio_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    vio_valid = 1'b0; vio_group = '0; vio_slave = '0; vio_master = '0; vio_domain = '0;
    vio_is_write = 1'b0; vio_is_read = 1'b0; vio_addr_hi = '0; vio_addr = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;

    // R1 reset state
    expect_rd(12'h300, 32'h0, "R1 gctrl");
    expect_rd(12'h310, 32'h0, "R1 shstat");
    expect_rd(12'h314, 32'h0, "R1 shsel");
    expect_rd(12'h320, 32'h0, "R1 shctrl");
    expect_rd(12'h100, 32'h0, "R1 stat0");
    expect_rd(12'h200, 32'h0, "R1 dbg0");
    expect_rd(12'h000, 32'hFFFF_FFFF, "R1 mask0");
    expect_rd(12'h004, 32'h0000_00FF, "R1 mask1");
    expect_irq(1'b0, "R1 irq");

    // R2 disabled capture ignored
    event_in(2'd1, 6'd3, 16'h1111, 6'd1, 1'b1, 1'b0, 4'h1, 32'h1);
    expect_rd(12'h310, 32'h0, "R2 off pending");
    expect_rd(12'h100, 32'h0, "R2 off stat");

    wr(12'h300, 32'h8000_0000);
    expect_rd(12'h300, 32'h8000_0000, "R2 enabled");
    wr(12'h000, 32'h0);
    wr(12'h004, 32'h0);

    // R3 / R9 / R10 capture
    event_in(2'd2, 6'd35, 16'h1234, 6'h15, 1'b1, 1'b0, 4'hA, 32'hDEAD_BEEF);
    expect_rd(12'h310, 32'h4, "R3 pending g2");
    expect_rd(12'h104, 32'h8, "R9 stat1 slave35");
    expect_irq(1'b1, "R10 irq raised");

    // R4 drop into pending group, then another group
    event_in(2'd2, 6'd1, 16'h9999, 6'h2, 1'b0, 1'b1, 4'h3, 32'h5555_0000);
    event_in(2'd0, 6'd5, 16'hBEEF, 6'h3, 1'b0, 1'b1, 4'h5, 32'h0000_1000);
    expect_rd(12'h310, 32'h5, "R3 pending g0 g2");

    // R5 transfer timing and R11/R4 content
    wr(12'h314, 32'h4);
    wr(12'h320, 32'h1);
    repeat (63) @(posedge clk); #1;
    expect_rd(12'h320, 32'h1, "R5 busy at 63");
    expect_rd(12'h320, 32'h3, "R5 done at 64");
    expect_rd(12'h200, 32'h1A55_1234, "R4 R11 dbg0 g2 with overflow");
    expect_rd(12'h204, 32'hDEAD_BEEF, "R11 dbg1 g2");

    // R6 stop, R7 clear
    wr(12'h320, 32'h0);
    expect_rd(12'h320, 32'h0, "R6 stop");
    wr(12'h310, 32'h4);
    expect_rd(12'h310, 32'h1, "R7 clear g2 only");

    // R11 second group, no overflow
    wr(12'h314, 32'h1);
    wr(12'h320, 32'h1);
    repeat (70) @(posedge clk); #1;
    expect_rd(12'h320, 32'h3, "R5 done g0");
    expect_rd(12'h200, 32'h0583_BEEF, "R11 dbg0 g0");
    expect_rd(12'h204, 32'h0000_1000, "R11 dbg1 g0");
    wr(12'h320, 32'h0);

    // R8 invalid selects
    wr(12'h314, 32'h0);
    wr(12'h320, 32'h1);
    repeat (70) @(posedge clk); #1;
    expect_rd(12'h320, 32'h0, "R8 zero select");
    wr(12'h314, 32'h3);
    wr(12'h320, 32'h1);
    repeat (70) @(posedge clk); #1;
    expect_rd(12'h320, 32'h0, "R8 multi-hot select");

    // R9 / R10 status clear and masking
    wr(12'h104, 32'h8);
    expect_rd(12'h104, 32'h0, "R9 stat1 cleared");
    expect_irq(1'b1, "R10 irq held by slave5");
    expect_rd(12'h100, 32'h22, "R9 stat0 slaves1,5");
    wr(12'h000, 32'h22);
    expect_irq(1'b0, "R10 masked");
    wr(12'h000, 32'h0);
    expect_irq(1'b1, "R10 unmasked");
    wr(12'h100, 32'h20);
    expect_irq(1'b1, "R10 slave1 still set");
    wr(12'h100, 32'h2);
    expect_irq(1'b0, "R10 all cleared");
    wr(12'h004, 32'hFFFF_FFFF);
    expect_rd(12'h004, 32'h0000_00FF, "R9 mask1 unused bits");
    event_in(2'd3, 6'd39, 16'h0, 6'h0, 1'b1, 1'b0, 4'h0, 32'h0);
    event_in(2'd3, 6'd45, 16'h0, 6'h0, 1'b1, 1'b0, 4'h0, 32'h0);
    expect_rd(12'h104, 32'h80, "R9 last slave and out of range");
    expect_irq(1'b0, "R10 masked slave39");

    // R2 disable
    wr(12'h310, 32'hF);
    wr(12'h300, 32'h4);
    expect_rd(12'h300, 32'h0, "R2 disabled");
    event_in(2'd1, 6'd2, 16'h7, 6'h1, 1'b1, 1'b0, 4'h0, 32'h7);
    expect_rd(12'h310, 32'h0, "R2 disabled pending");
    expect_rd(12'h100, 32'h0, "R2 disabled stat");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule